// File: doc/BRIEF.md
# Idle State Selection Engine

This block picks the deepest low-power state a processor core may enter, given how long the core is expected to stay idle and how quickly it must be able to wake. Software or firmware fills a small table of candidate states. Each slot holds an entry latency, an exit latency and a minimum residency. A slot may also carry an explicit worst-case wakeup latency, and it has a flag that marks loss of the local timer. The plain wait-for-interrupt standby state is always allowed. It has no table slot and is the answer whenever no slot fits.

A selection starts with a valid/ready request that carries the predicted time to the next wake interrupt and the system's wake-latency limit. The engine then walks the table one slot per cycle from a synchronous-read memory. It keeps the highest-numbered slot that fits and returns a code with a one-cycle done pulse after a fixed number of cycles. Slots are meant to be programmed in order from shallowest to deepest. A slot fits when the predicted idle time reaches its break-even residency (a figure that already includes preparation and entry) and its worst-case wakeup latency stays within the limit.

Top module: `idle_select`

## Requirements
- R1: After reset, req_ready is 1, res_valid is 0, res_code is 0, and every table slot is marked unused.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 until the result is produced, and req_valid asserted in that time has no effect on the result.
- R3: res_valid is a single-cycle pulse that rises exactly NUM_STATES+1 clock edges after the edge that took the request.
- R4: res_code 0 means the standby state, and res_code k (1..NUM_STATES) means table slot k-1. Among the fitting slots, the one with the highest index is returned.
- R5: A slot fits only if req_pred is greater than or equal to its minimum residency. Equality fits.
- R6: A slot fits only if its effective wakeup latency is less than or equal to req_limit. Equality fits.
- R7: A slot's effective wakeup latency is its explicit wakeup latency when its wake-given bit is 1, and its entry latency plus exit latency (computed one bit wider) when that bit is 0.
- R8: Slots whose valid bit is 0 never fit. When no slot fits, res_code is 0, res_wake_lat is 0 and res_timer_lost is 0.
- R9: With a result, res_wake_lat carries the effective wakeup latency of the chosen slot and res_timer_lost carries its timer-lost flag.
- R10: A cycle with cfg_we high writes all fields and the valid bit of slot cfg_addr at once. The new contents apply to every request taken afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one table slot |
| cfg_addr | input | IDX_W | Slot number being written |
| cfg_valid | input | 1 | Slot in use |
| cfg_entry_lat | input | TW | Entry latency |
| cfg_exit_lat | input | TW | Exit latency |
| cfg_min_res | input | TW | Minimum residency (break-even time) |
| cfg_wake_lat | input | TW | Explicit worst-case wakeup latency |
| cfg_wake_given | input | 1 | 1: use cfg_wake_lat, 0: use entry plus exit |
| cfg_timer_lost | input | 1 | State loses the local timer |
| req_valid | input | 1 | Selection request |
| req_ready | output | 1 | Engine can take a request |
| req_pred | input | TW | Predicted time to next wake |
| req_limit | input | TW | Largest allowed wakeup latency |
| res_valid | output | 1 | One-cycle result pulse |
| res_code | output | CODE_W | 0 = standby, k = slot k-1 |
| res_wake_lat | output | TW+1 | Effective wakeup latency of the choice |
| res_timer_lost | output | 1 | Timer-lost flag of the choice |

## Verification
A small table is programmed with two retention-like and two sleep-like states, one with a default wakeup latency and one with an explicit wakeup latency per depth. The bench then sweeps a grid of predicted times against latency limits. The grid values sit on and just below each residency and each effective latency, so off-by-one comparisons and the choice between the default and explicit wakeup latency show up as wrong codes. A second table adds an unused slot whose figures would otherwise always fit, plus a cheap deep slot, to tell apart slot-order priority and valid masking. A final sweep with every slot cleared must return only standby. Requests held high during a scan test that busy-time requests are ignored.

// File: rtl/idle_sel_pkg.sv
package idle_sel_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SCAN = 2'd1,
    PH_TAIL = 2'd2
  } scan_phase_e;
endpackage

// File: rtl/idle_tbl_ram.sv
module idle_tbl_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 66,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/idle_fit_eval.sv
module idle_fit_eval #(
  parameter int TW = 16
) (
  input  logic          slot_used,
  input  logic [TW-1:0] entry_lat,
  input  logic [TW-1:0] exit_lat,
  input  logic [TW-1:0] min_res,
  input  logic [TW-1:0] wake_lat,
  input  logic          wake_given,
  input  logic [TW-1:0] pred,
  input  logic [TW-1:0] limit,
  output logic          fits,
  output logic [TW:0]   eff_lat
);
  logic [TW:0] sum_lat;
  logic        res_ok;
  logic        lat_ok;

  always_comb begin
    sum_lat = {1'b0, entry_lat} + {1'b0, exit_lat};
    eff_lat = wake_given ? {1'b0, wake_lat} : sum_lat;
    res_ok  = (pred >= min_res);
    lat_ok  = (eff_lat <= {1'b0, limit});
    fits    = slot_used && res_ok && lat_ok;
  end
endmodule

// File: rtl/idle_scan_ctrl.sv
module idle_scan_ctrl
  import idle_sel_pkg::*;
#(
  parameter int NUM_STATES = 8,
  parameter int TW = 16,
  localparam int IDX_W  = $clog2(NUM_STATES),
  localparam int CODE_W = $clog2(NUM_STATES + 1),
  localparam int LAT_CW = $clog2(NUM_STATES + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TW-1:0]     req_pred,
  input  logic [TW-1:0]     req_limit,
  output logic [TW-1:0]     pred_q,
  output logic [TW-1:0]     limit_q,
  output logic [IDX_W-1:0]  rd_addr,
  output logic [IDX_W-1:0]  chk_idx,
  input  logic              chk_fit,
  input  logic [TW:0]       chk_eff,
  input  logic              chk_tl,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code,
  output logic [TW:0]       res_wake_lat,
  output logic              res_timer_lost
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STATES - 1);

  scan_phase_e       phase;
  logic [IDX_W-1:0]  cnt;
  logic              chk_v;
  logic [CODE_W-1:0] best_code;
  logic [TW:0]       best_lat;
  logic              best_tl;
  logic [CODE_W-1:0] chk_code;

  assign req_ready = (phase == PH_IDLE);
  assign rd_addr   = cnt;
  assign chk_code  = CODE_W'(chk_idx) + CODE_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase          <= PH_IDLE;
      cnt            <= '0;
      chk_v          <= 1'b0;
      chk_idx        <= '0;
      best_code      <= '0;
      best_lat       <= '0;
      best_tl        <= 1'b0;
      pred_q         <= '0;
      limit_q        <= '0;
      res_valid      <= 1'b0;
      res_code       <= '0;
      res_wake_lat   <= '0;
      res_timer_lost <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      chk_v     <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            pred_q    <= req_pred;
            limit_q   <= req_limit;
            cnt       <= '0;
            best_code <= '0;
            best_lat  <= '0;
            best_tl   <= 1'b0;
            phase     <= PH_SCAN;
          end
        end
        PH_SCAN: begin
          chk_v   <= 1'b1;
          chk_idx <= cnt;
          cnt     <= cnt + 1'b1;
          if (cnt == LAST_IDX) phase <= PH_TAIL;
        end
        PH_TAIL: begin
          phase     <= PH_IDLE;
          res_valid <= 1'b1;
          if (chk_fit) begin
            res_code       <= chk_code;
            res_wake_lat   <= chk_eff;
            res_timer_lost <= chk_tl;
          end else begin
            res_code       <= best_code;
            res_wake_lat   <= best_lat;
            res_timer_lost <= best_tl;
          end
        end
        default: phase <= PH_IDLE;
      endcase
      if (chk_v && chk_fit) begin
        best_code <= chk_code;
        best_lat  <= chk_eff;
        best_tl   <= chk_tl;
      end
    end
  end

  logic [LAT_CW-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (req_valid && req_ready) lat_cnt <= '0;
    else if (phase != PH_IDLE) lat_cnt <= lat_cnt + 1'b1;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R3
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (lat_cnt == LAT_CW'(NUM_STATES + 1))); // R3
  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (!req_ready) |=> $stable(pred_q) && $stable(limit_q)); // R2
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_code <= CODE_W'(NUM_STATES))); // R4
  AST_WAKE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_wake_lat <= {1'b0, limit_q})); // R6
  AST_STANDBY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == '0) |-> (res_wake_lat == '0 && !res_timer_lost)); // R8
endmodule

// File: rtl/idle_select.sv
module idle_select #(
  parameter int NUM_STATES = 8,
  parameter int TW = 16,
  localparam int IDX_W  = $clog2(NUM_STATES),
  localparam int CODE_W = $clog2(NUM_STATES + 1),
  localparam int ENT_W  = 4 * TW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic              cfg_valid,
  input  logic [TW-1:0]     cfg_entry_lat,
  input  logic [TW-1:0]     cfg_exit_lat,
  input  logic [TW-1:0]     cfg_min_res,
  input  logic [TW-1:0]     cfg_wake_lat,
  input  logic              cfg_wake_given,
  input  logic              cfg_timer_lost,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [TW-1:0]     req_pred,
  input  logic [TW-1:0]     req_limit,
  output logic              res_valid,
  output logic [CODE_W-1:0] res_code,
  output logic [TW:0]       res_wake_lat,
  output logic              res_timer_lost
);
  logic [NUM_STATES-1:0] used_q;
  logic [ENT_W-1:0]      wr_word;
  logic [ENT_W-1:0]      rd_word;
  logic [IDX_W-1:0]      rd_addr;
  logic [IDX_W-1:0]      chk_idx;
  logic [TW-1:0]         pred_q;
  logic [TW-1:0]         limit_q;
  logic                  chk_fit;
  logic [TW:0]           chk_eff;

  // Slot-in-use bits live in flops so they clear on reset; the rest is RAM.
  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else if (cfg_we) used_q[cfg_addr] <= cfg_valid;
  end

  assign wr_word = {cfg_timer_lost, cfg_wake_given, cfg_wake_lat,
                    cfg_min_res, cfg_exit_lat, cfg_entry_lat};

  idle_tbl_ram #(.DEPTH(NUM_STATES), .WIDTH(ENT_W)) u_tbl (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (wr_word),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  idle_fit_eval #(.TW(TW)) u_fit (
    .slot_used  (used_q[chk_idx]),
    .entry_lat  (rd_word[0 +: TW]),
    .exit_lat   (rd_word[TW +: TW]),
    .min_res    (rd_word[2*TW +: TW]),
    .wake_lat   (rd_word[3*TW +: TW]),
    .wake_given (rd_word[4*TW]),
    .pred       (pred_q),
    .limit      (limit_q),
    .fits       (chk_fit),
    .eff_lat    (chk_eff)
  );

  idle_scan_ctrl #(.NUM_STATES(NUM_STATES), .TW(TW)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_pred       (req_pred),
    .req_limit      (req_limit),
    .pred_q         (pred_q),
    .limit_q        (limit_q),
    .rd_addr        (rd_addr),
    .chk_idx        (chk_idx),
    .chk_fit        (chk_fit),
    .chk_eff        (chk_eff),
    .chk_tl         (rd_word[4*TW+1]),
    .res_valid      (res_valid),
    .res_code       (res_code),
    .res_wake_lat   (res_wake_lat),
    .res_timer_lost (res_timer_lost)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (req_ready && !res_valid)); // R1
endmodule

// File: tb/idle_select_tb.sv
module idle_select_tb_top;
  localparam int N  = 8;
  localparam int TW = 16;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [IW-1:0] cfg_addr;
  logic          cfg_valid;
  logic [TW-1:0] cfg_entry_lat, cfg_exit_lat, cfg_min_res, cfg_wake_lat;
  logic          cfg_wake_given, cfg_timer_lost;
  logic          req_valid, req_ready;
  logic [TW-1:0] req_pred, req_limit;
  logic          res_valid;
  logic [CW-1:0] res_code;
  logic [TW:0]   res_wake_lat;
  logic          res_timer_lost;

  int total = 0;
  int fails = 0;

  int m_v [N];
  int m_en[N];
  int m_ex[N];
  int m_mr[N];
  int m_wl[N];
  int m_wg[N];
  int m_tl[N];

  always #4 clk = ~clk;

  idle_select #(.NUM_STATES(N), .TW(TW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_valid(cfg_valid),
    .cfg_entry_lat(cfg_entry_lat), .cfg_exit_lat(cfg_exit_lat),
    .cfg_min_res(cfg_min_res), .cfg_wake_lat(cfg_wake_lat),
    .cfg_wake_given(cfg_wake_given), .cfg_timer_lost(cfg_timer_lost),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pred(req_pred), .req_limit(req_limit),
    .res_valid(res_valid), .res_code(res_code),
    .res_wake_lat(res_wake_lat), .res_timer_lost(res_timer_lost)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_slot(input int a, input int v, input int en, input int ex,
                         input int mr, input int wl, input int wg, input int tl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = IW'(a); cfg_valid = v[0];
    cfg_entry_lat = TW'(en); cfg_exit_lat = TW'(ex); cfg_min_res = TW'(mr);
    cfg_wake_lat = TW'(wl); cfg_wake_given = wg[0]; cfg_timer_lost = tl[0];
    m_v[a] = v; m_en[a] = en; m_ex[a] = ex; m_mr[a] = mr;
    m_wl[a] = wl; m_wg[a] = wg; m_tl[a] = tl;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Expected answer from the requirements (R4..R9)
  task automatic model(input int pred, input int lim,
                       output int ec, output int el, output int et);
    ec = 0; el = 0; et = 0;
    for (int i = 0; i < N; i++) begin
      int eff;
      eff = (m_wg[i] != 0) ? m_wl[i] : (m_en[i] + m_ex[i]);
      if (m_v[i] != 0 && pred >= m_mr[i] && eff <= lim) begin
        ec = i + 1; el = eff; et = m_tl[i];
      end
    end
  endtask

  task automatic run_sel(input int pred, input int lim, input bit noise);
    int ec, el, et, cyc;
    model(pred, lim, ec, el, et);
    @(negedge clk);
    req_valid = 1'b1; req_pred = TW'(pred); req_limit = TW'(lim);
    @(negedge clk);
    chk("R2 ready low while busy", int'(req_ready), 0);
    if (noise) begin
      req_pred = '0; req_limit = '0;   // busy-time request, must be ignored
    end else begin
      req_valid = 1'b0;
    end
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!res_valid && cyc < 40);
    req_valid = 1'b0;
    chk("R3 latency", cyc, N + 1);
    chk(noise ? "R2/R4/R5/R6 code with busy request" : "R4/R5/R6/R7 code",
        int'(res_code), ec);
    chk("R9/R7 wake latency", int'(res_wake_lat), el);
    chk("R9 timer lost", int'(res_timer_lost), et);
    @(negedge clk);
    chk("R3 single pulse", int'(res_valid), 0);
  endtask

  initial begin
    int preds[10]  = '{0, 79, 80, 249, 250, 949, 950, 2699, 2700, 65535};
    int limits[11] = '{0, 59, 60, 129, 130, 149, 749, 750, 1499, 1500, 65535};
    int p2[6]      = '{0, 99, 100, 300, 949, 950};
    int l2[6]      = '{0, 4, 5, 60, 750, 65535};
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_en[i] = 0; m_ex[i] = 0; m_mr[i] = 0;
      m_wl[i] = 0; m_wg[i] = 0; m_tl[i] = 0;
    end
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_valid = 1'b0;
    cfg_entry_lat = '0; cfg_exit_lat = '0; cfg_min_res = '0; cfg_wake_lat = '0;
    cfg_wake_given = 1'b0; cfg_timer_lost = 1'b0;
    req_valid = 1'b0; req_pred = '0; req_limit = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 no result after reset", int'(res_valid), 0);
    chk("R1 code after reset", int'(res_code), 0);
    // R1/R8: empty table gives standby
    run_sel(65535, 65535, 1'b0);

    // R10: shallow-to-deep table
    wr_slot(0, 1, 20, 40, 80, 0, 0, 0);
    wr_slot(1, 1, 50, 100, 250, 130, 1, 1);
    wr_slot(2, 1, 250, 500, 950, 0, 0, 1);
    wr_slot(3, 1, 600, 1100, 2700, 1500, 1, 1);
    foreach (preds[i]) foreach (limits[j]) run_sel(preds[i], limits[j], 1'b0);

    // R2: requests held during the scan are ignored
    run_sel(2700, 1500, 1'b1);
    run_sel(80, 60, 1'b1);

    // R8/R4: unused slot with figures that always fit, and a cheap deep slot
    wr_slot(4, 1, 1, 1, 100, 0, 0, 0);
    wr_slot(5, 0, 0, 0, 0, 0, 0, 1);
    wr_slot(6, 1, 9, 9, 300, 5, 1, 1);
    foreach (p2[i]) foreach (l2[j]) run_sel(p2[i], l2[j], 1'b0);

    // R8: clear every slot, only standby remains
    for (int a = 0; a < N; a++) wr_slot(a, 0, 1, 1, 0, 0, 0, 1);
    run_sel(0, 0, 1'b0);
    run_sel(65535, 65535, 1'b0);
    run_sel(950, 750, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule